// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a synchronous, single-outstanding request port to an external asynchronous static RAM. The memory holds 262,144 four-bit words on 18 address lines, uses one set of 4 pins for both directions of data, and has three active-low controls: chip select, write enable and output enable. A client offers one read or one write with a valid/ready handshake. The controller then plays out the matching strobe sequence, holding each phase for a whole number of clock cycles derived from the memory's nanosecond minimums, and returns read data with a one-cycle valid pulse.

The data pins are driven through a separate output value and drive enable, with the pin value read back on an input. A write first holds write enable low with the controller's drivers off for a turnaround phase, so the memory outputs have reached high impedance before data is driven. Data stays driven for one cycle after write enable rises. Output enable is held high for the whole write. Between accesses all three strobes sit high and nothing is driven.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all 1 and `mem_dq_oe` is 0.
- R2: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are 1, and `req_ready` stays low until that access is complete.
- R3: A read (`req_write`=0) holds `mem_cs_n`=0 and `mem_oe_n`=0 for exactly RD_CYC cycles, with `mem_we_n`=1 throughout.
- R4: Read data is sampled from `mem_dq_in` on the last cycle with `mem_oe_n` low. In the following cycle `rd_valid` is 1 for exactly one cycle, and `rd_data` holds the sampled word.
- R5: A write (`req_write`=1) holds `mem_we_n`=0 and `mem_cs_n`=0 for exactly TA_CYC+WP_CYC cycles, and `mem_oe_n` stays 1 throughout.
- R6: During a write, `mem_dq_oe` rises only after `mem_we_n` has been low for TA_CYC cycles. It then stays 1 for WP_CYC cycles with write enable low, plus the one cycle in which `mem_we_n` has returned to 1.
- R7: `mem_addr` equals the accepted `req_addr` for the whole access. It changes only at acceptance, never while `mem_we_n` is low.
- R8: Each phase length is ceil(t_ns / CLK_NS) with a minimum of one: RD_CYC from T_RC_NS, TA_CYC from T_HZ_NS, and WP_CYC as the larger of the counts from T_WP_NS and T_DW_NS.
- R9: A read issued right after a write to the same address returns the written word, and the controller never drives the data pins while the memory may still be driving them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse when read data is ready |
| rd_data | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | DATA_W | Value driven onto the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | DATA_W | Value read back from the data pins |

## Verification
The bench sweeps every address of a small 8-bit-address configuration. It writes an address-dependent pattern across the whole space and then reads it back, which exposes dropped or aliased address bits. It then alternates a write and an immediate read to the same address with a second pattern, which exercises the turnaround between directions and catches stale data. The memory model returns wrong data until output enable has been low for the computed access time, and it stores wrong data if the drive was shorter than the setup time or was released before write enable rose. Strobe widths, the drive window, the valid pulse position and address stability are therefore measured on every access.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_RD_ACC   = 3'd1,
    PH_RD_DONE  = 3'd2,
    PH_WR_TA    = 3'd3,
    PH_WR_PULSE = 3'd4,
    PH_WR_HOLD  = 3'd5
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } strobe_t;

  // whole cycles covering a nanosecond minimum, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // pin levels wanted in each phase
  function automatic strobe_t strobes_for(input phase_e p);
    strobe_t s;
    s = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
    case (p)
      PH_RD_ACC:   s = '{cs_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
      PH_WR_TA:    s = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b0};
      PH_WR_PULSE: s = '{cs_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
      PH_WR_HOLD:  s = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
      default:     s = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned TA_CYC = 1,
  parameter int unsigned WP_CYC = 2,
  parameter int unsigned CNT_W  = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   accept,
  output logic   rd_last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign accept   = (phase_q == PH_IDLE) && req_valid;
  assign rd_last  = (phase_q == PH_RD_ACC) && cnt_zero;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: if (req_valid) begin
        if (req_write) begin
          phase_d = PH_WR_TA;
          cnt_d   = CNT_W'(TA_CYC - 1);
        end else begin
          phase_d = PH_RD_ACC;
          cnt_d   = CNT_W'(RD_CYC - 1);
        end
      end
      PH_RD_ACC: begin
        if (cnt_zero) phase_d = PH_RD_DONE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      PH_RD_DONE: phase_d = PH_IDLE;
      PH_WR_TA: begin
        if (cnt_zero) begin
          phase_d = PH_WR_PULSE;
          cnt_d   = CNT_W'(WP_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_WR_PULSE: begin
        if (cnt_zero) phase_d = PH_WR_HOLD;
        else          cnt_d   = cnt_q - 1'b1;
      end
      PH_WR_HOLD: phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2: a request is only taken from idle, and busy phases never restart
  assert_accept_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> (phase_q != PH_RD_ACC || $past(phase_q) == PH_RD_ACC || $past(phase_q) == PH_IDLE));

  // R8: read phase never runs beyond its computed length
  assert_rd_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RD_ACC) |-> (cnt_q <= CNT_W'(RD_CYC - 1)));

endmodule

// File: rtl/sram_ctrl_io.sv
module sram_ctrl_io
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_e            phase_d,
  input  logic              rd_last,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  strobe_t nxt;
  assign nxt = strobes_for(phase_d);

  // strobes come straight from flops so the pins never glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      mem_cs_n  <= nxt.cs_n;
      mem_we_n  <= nxt.we_n;
      mem_oe_n  <= nxt.oe_n;
      mem_dq_oe <= nxt.drv;
      rd_valid  <= (phase_d == PH_RD_DONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (rd_last) rd_data <= mem_dq_in;
    end
  end

  // R6: the controller drives only while memory outputs are disabled
  assert_drive_oe_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R6: drive starts only after write enable has already been low
  assert_drive_after_ta_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && !$past(mem_we_n)));

  // R6: data is still driven in the cycle write enable returns high
  assert_drive_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  // R7: no address movement inside a write window
  assert_addr_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

  // R4: the read-valid strobe is a single-cycle pulse
  assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R5: write enable is only ever low inside a chip select window
  assert_we_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned DATA_W  = 4,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_RC_NS = 15,
  parameter int unsigned T_WP_NS = 12,
  parameter int unsigned T_DW_NS = 7,
  parameter int unsigned T_HZ_NS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned RD_CYC  = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int unsigned TA_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned WP_CYC  = max_u(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int unsigned CNT_MAX = max_u(RD_CYC, max_u(TA_CYC, WP_CYC));
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  phase_e phase_q, phase_d;
  logic   accept;
  logic   rd_last;

  assign req_ready = (phase_q == PH_IDLE);

  sram_ctrl_seq #(
    .RD_CYC(RD_CYC), .TA_CYC(TA_CYC), .WP_CYC(WP_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .phase_q(phase_q), .phase_d(phase_d),
    .accept(accept), .rd_last(rd_last)
  );

  sram_ctrl_io #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_io (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .req_addr(req_addr), .req_wdata(req_wdata),
    .phase_d(phase_d), .rd_last(rd_last), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R1: idle means fully deselected and not driving
  assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R7: the address moves only as a result of a handshake
  assert_addr_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> $past(req_valid && req_ready));

  // R3: output enable is never low together with write enable
  assert_read_we_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n));

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  localparam int AW = 8;
  localparam int DW = 4;
  localparam int CLKP = 10;
  // phase lengths restated from the requirements: ceil(ns/period), at least 1
  localparam int RD_B = ((15 + CLKP - 1) / CLKP) < 1 ? 1 : (15 + CLKP - 1) / CLKP;
  localparam int TA_B = ((7 + CLKP - 1) / CLKP) < 1 ? 1 : (7 + CLKP - 1) / CLKP;
  localparam int WP0  = (12 + CLKP - 1) / CLKP;
  localparam int DS_B = (7 + CLKP - 1) / CLKP;
  localparam int WP_B = (WP0 > DS_B) ? WP0 : DS_B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int checks = 0, errors = 0, cyc = 0, contention = 0;

  always #(CLKP/2) clk = ~clk;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLKP)) i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // ---------------- memory model ----------------
  logic [DW-1:0] mdl [1 << AW];
  logic read_now, prev_read, prev_wr;
  int rdcnt = 0, setup_cnt = 0;
  logic [DW-1:0] wbuf;
  logic [AW-1:0] waddr;

  assign read_now  = !mem_cs_n && mem_we_n && !mem_oe_n;
  assign mem_dq_in = (read_now && rdcnt >= RD_B) ? mdl[mem_addr] : ~mdl[mem_addr];

  initial begin
    for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
    prev_read = 1'b0; prev_wr = 1'b0; wbuf = '0; waddr = '0;
  end

  always @(negedge clk) begin
    if (mem_dq_oe && (read_now || prev_read)) contention++;
    prev_read = read_now;
    rdcnt = read_now ? rdcnt + 1 : 0;
    if (!mem_cs_n && !mem_we_n) begin
      waddr = mem_addr;
      if (mem_dq_oe) begin wbuf = mem_dq_out; setup_cnt++; end
      prev_wr = 1'b1;
    end else begin
      if (prev_wr)
        mdl[waddr] = (setup_cnt >= DS_B && mem_dq_oe) ? wbuf : ~wbuf;
      setup_cnt = 0;
      prev_wr = 1'b0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * k + 3 * k + 1) % 16);
  endfunction

  task automatic do_op(input bit wr, input int a, input logic [DW-1:0] d, output logic [DW-1:0] rdat);
    int idx, cs_lo, we_lo, oe_lo, drv, first_drv, rv_cnt, rv_idx, addr_bad;
    rdat = '0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    idx = 1; cs_lo = 0; we_lo = 0; oe_lo = 0; drv = 0; first_drv = 0;
    rv_cnt = 0; rv_idx = 0; addr_bad = 0;
    while (!req_ready && idx < 40) begin
      if (!mem_cs_n) cs_lo++;
      if (!mem_we_n) we_lo++;
      if (!mem_oe_n) oe_lo++;
      if (mem_dq_oe) begin drv++; if (first_drv == 0) first_drv = idx; end
      if (rd_valid) begin rv_cnt++; rv_idx = idx; rdat = rd_data; end
      if (mem_addr != AW'(a)) addr_bad++;
      @(negedge clk);
      idx++;
    end
    if (wr) begin
      chk("R2", "write busy cycles", idx - 1, TA_B + WP_B + 1);
      chk("R5", "we_n low cycles", we_lo, TA_B + WP_B);
      chk("R5", "cs_n low cycles", cs_lo, TA_B + WP_B);
      chk("R5", "oe_n low in write", oe_lo, 0);
      chk("R6", "first drive index", first_drv, TA_B + 1);
      chk("R6", "drive cycles", drv, WP_B + 1);
    end else begin
      chk("R2", "read busy cycles", idx - 1, RD_B + 1);
      chk("R3", "cs_n low cycles", cs_lo, RD_B);
      chk("R3", "oe_n low cycles", oe_lo, RD_B);
      chk("R3", "we_n low in read", we_lo, 0);
      chk("R4", "rd_valid count", rv_cnt, 1);
      chk("R4", "rd_valid index", rv_idx, RD_B + 1);
      chk("R8", "no drive in read", drv, 0);
    end
    chk("R7", "address mismatch cycles", addr_bad, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    repeat (3) @(negedge clk);
    chk("R1", "cs_n in reset", int'(mem_cs_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(req_ready), 1);
    chk("R1", "strobes idle", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 4'b1110);
    chk("R1", "rd_valid idle", int'(rd_valid), 0);

    // write sweep then read sweep over the whole space
    for (int a = 0; a < (1 << AW); a++) do_op(1'b1, a, pat(a, 5), r);
    for (int a = 0; a < (1 << AW); a++) begin
      do_op(1'b0, a, '0, r);
      chk("R4", $sformatf("read data addr %0d", a), int'(r), int'(pat(a, 5)));
    end

    // back-to-back write then read on the same word
    for (int a = 0; a < (1 << AW); a += 3) begin
      do_op(1'b1, a, pat(a, 7), r);
      do_op(1'b0, a, '0, r);
      chk("R9", $sformatf("write-read addr %0d", a), int'(r), int'(pat(a, 7)));
    end

    @(negedge clk);
    chk("R1", "idle strobes at end", int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 4'b1110);
    chk("R9", "bus contention cycles", contention, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule